// File: doc/BRIEF.md
# Hardware Spinlock Bank

A bank of mutual-exclusion flags shared by several bus masters. Each lock has its own word register. A master claims a lock by reading that register. If the lock was free, it becomes held and the read data is a single set bit at the lock's index. If the lock was already held, the read data is zero and the lock stays held. Any write to a lock register frees that lock. The value written does not matter, so the block has no write-data input. A separate status word shows every lock's state at once, one bit per lock.

The hardware keeps no owner. A master that already holds a lock and reads it again gets zero, just like any other master. When several masters hit the same free lock in one cycle, a fixed priority decides the winner: the lowest-numbered port wins. Lock state survives everything except this block's own reset, so processor resets elsewhere do not release locks.

Top module: `hw_lock_bank`

## Requirements
- R1: While `rst_ni` is low, every lock is free and every `rdata_o` word is 0. After reset is released, the status word reads 0.
- R2: A read at byte offset 0x100 + 4*i (i from 0 to 31) of a free lock i makes the lock held. In the cycle after the request, `rdata_o` of that port is 1 << i.
- R3: A read of a held lock returns 0 and leaves the lock held. This also applies when the reading port is the one that claimed it.
- R4: A write at the register of lock i, with any data, makes lock i free.
- R5: A read at offset 0x0FC returns the status word. Bit i is 1 exactly when lock i is held. The status reflects the state before any claim or release in the same cycle. Reading the status changes no lock, and writes to 0x0FC are ignored.
- R6: When more than one port reads the same free lock in one cycle, only the lowest-numbered port is granted. The other ports read 0. Claims of different locks in one cycle are all granted.
- R7: A claim is judged on the state at the start of the cycle. A claim that meets a release of the same held lock in that cycle fails, and the lock ends free. A claim that meets a write to the same free lock in that cycle succeeds, and the lock ends held.
- R8: Reads of unmapped offsets return 0. Reads of offsets that are not word aligned (bits 1:0 not 00) also return 0. Writes to such offsets change no lock.
- R9: `rdata_o` of a port is a register. It is updated one cycle after each request and is 0 in the cycle after a cycle with no read on that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the block; frees all locks |
| req_i | input | N_PORTS | Per-port access request, one cycle per access |
| we_i | input | N_PORTS | Per-port write (1) or read (0) |
| addr_i | input | N_PORTS x ADDR_W | Per-port byte offset |
| rdata_o | output | N_PORTS x DATA_W | Per-port read data, one cycle after the request |

## Verification
The hardest cases to reach are collisions inside a single cycle. These are two ports claiming the same free lock, a claim meeting a release of the same lock, and a status read during a claim. Ordinary sequential use never produces any of them. The vector table drives both ports in the same cycle with crafted address pairs. Each collision row is followed by a status read, which shows through the normal read path exactly which locks ended held. A mid-run reset with several locks held then shows that only the block's own reset frees them.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_LOCKS = 32;
  localparam int unsigned N_PORTS = 2;
  localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] STAT_OFF  = 12'h0FC;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_LOCK_RD = 2'd1,
    OP_LOCK_WR = 2'd2,
    OP_STAT_RD = 2'd3
  } lock_op_e;
endpackage

// File: rtl/hw_lock_decode.sv
module hw_lock_decode
  import hw_lock_pkg::*;
#(
  parameter int unsigned     AW      = ADDR_W,
  parameter int unsigned     NL      = N_LOCKS,
  parameter logic [AW-1:0]   BASE    = LOCK_BASE,
  parameter logic [AW-1:0]   STAT    = STAT_OFF
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output lock_op_e      op_o,
  output logic [NL-1:0] hot_o
);
  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] BASE_W = BASE[AW-1:2];
  localparam logic [WW-1:0] STAT_W = STAT[AW-1:2];

  logic [WW-1:0] word, rel;
  logic          aligned, in_lock;

  assign word    = addr_i[AW-1:2];
  assign rel     = word - BASE_W;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_lock = aligned && (word >= BASE_W) && (rel < WW'(NL));

  always_comb begin
    op_o  = OP_NONE;
    hot_o = '0;
    if (req_i && in_lock) begin
      op_o  = we_i ? OP_LOCK_WR : OP_LOCK_RD;
      hot_o = {{(NL-1){1'b0}}, 1'b1} << rel;
    end else if (req_i && aligned && !we_i && word == STAT_W) begin
      op_o = OP_STAT_RD;
    end
  end
endmodule

// File: rtl/hw_lock_arbiter.sv
module hw_lock_arbiter #(
  parameter int unsigned NL = hw_lock_pkg::N_LOCKS,
  parameter int unsigned NP = hw_lock_pkg::N_PORTS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NL-1:0]          held_i,
  input  logic [NP-1:0][NL-1:0]  claim_i,
  output logic [NP-1:0][NL-1:0]  grant_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lock
    logic [NP-1:0] col;
    always_comb begin
      logic taken;
      taken = held_i[l];
      for (int p = 0; p < NP; p++) begin
        grant_o[p][l] = claim_i[p][l] & ~taken;
        taken         = taken | claim_i[p][l];
      end
    end
    for (genvar p = 0; p < NP; p++) begin : g_col
      assign col[p] = grant_o[p][l];
    end

    // R6: at most one port wins a lock
    a_r6_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
    // R3: a held lock is never granted
    a_r3_no_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      held_i[l] |-> (col == '0));
  end
endmodule

// File: rtl/hw_lock_state.sv
module hw_lock_state #(
  parameter int unsigned NL = hw_lock_pkg::N_LOCKS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] set_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] held_o
);
  logic [NL-1:0] held_q;

  // grant of a free lock beats a concurrent release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= (held_q & ~clr_i) | set_i;
  end
  assign held_o = held_q;

  for (genvar l = 0; l < NL; l++) begin : g_chk
    a_r2_grant_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[l] |=> held_q[l]);
    a_r3_held_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (held_q[l] && !clr_i[l]) |=> held_q[l]);
    a_r4_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[l] && !set_i[l]) |=> !held_q[l]);
  end

  // R5 / R8: no lock traffic means no state change
  a_r5_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(held_q));
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hw_lock_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NL = N_LOCKS,
  parameter int unsigned NP = N_PORTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NP-1:0]         req_i,
  input  logic [NP-1:0]         we_i,
  input  logic [NP-1:0][AW-1:0] addr_i,
  output logic [NP-1:0][DW-1:0] rdata_o
);
  lock_op_e [NP-1:0]    op;
  logic [NP-1:0][NL-1:0] hot, claim, grant;
  logic [NL-1:0]         held, set, clr;

  for (genvar p = 0; p < NP; p++) begin : g_port
    hw_lock_decode #(.AW(AW), .NL(NL)) u_dec (
      .req_i  (req_i[p]),
      .we_i   (we_i[p]),
      .addr_i (addr_i[p]),
      .op_o   (op[p]),
      .hot_o  (hot[p])
    );
    assign claim[p] = (op[p] == OP_LOCK_RD) ? hot[p] : '0;
  end

  hw_lock_arbiter #(.NL(NL), .NP(NP)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .held_i  (held),
    .claim_i (claim),
    .grant_o (grant)
  );

  always_comb begin
    set = '0;
    clr = '0;
    for (int p = 0; p < NP; p++) begin
      set = set | grant[p];
      if (op[p] == OP_LOCK_WR) clr = clr | hot[p];
    end
  end

  hw_lock_state #(.NL(NL)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .held_o (held)
  );

  for (genvar p = 0; p < NP; p++) begin : g_rd
    logic [DW-1:0] rd_d;
    always_comb begin
      unique case (op[p])
        OP_LOCK_RD: rd_d = DW'(grant[p]);
        OP_STAT_RD: rd_d = DW'(held);
        default:    rd_d = '0;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o[p] <= '0;
      else         rdata_o[p] <= rd_d;
    end

    // R3: reading a lock that was held returns zero
    a_r3_held_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op[p] == OP_LOCK_RD && (hot[p] & held) != '0) |=> (rdata_o[p] == '0));
    // R9: no read, no data
    a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_i[p] || we_i[p]) |=> (rdata_o[p] == '0));
  end
endmodule

// File: tb/hw_lock_bank_bench.sv
module hw_lock_bank_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NV = 20;
  localparam int VW = 92;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           req = '0;
  logic [1:0]           we = '0;
  logic [1:0][AW-1:0]   addr = '0;
  logic [1:0][DW-1:0]   rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hw_lock_bank u_hw_lock_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .rdata_o(rdata)
  );

  // {req0,we0,addr0, req1,we1,addr1, exp0, exp1}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h0,        32'h0},        // R1 status after reset
    {2'b10, 12'h100, 2'b00, 12'h000, 32'h1,        32'h0},        // R2 claim lock 0
    {2'b10, 12'h100, 2'b00, 12'h000, 32'h0,        32'h0},        // R3 same port again
    {2'b00, 12'h000, 2'b10, 12'h100, 32'h0,        32'h0},        // R3 other port
    {2'b10, 12'h0FC, 2'b10, 12'h17C, 32'h1,        32'h80000000}, // R5 status pre-update, R2 lock 31
    {2'b10, 12'h0FC, 2'b11, 12'h0FC, 32'h80000001, 32'h0},        // R5 write to status
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h80000001, 32'h0},        // R5 write ignored
    {2'b11, 12'h100, 2'b00, 12'h000, 32'h0,        32'h0},        // R4 release lock 0
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h80000000, 32'h0},        // R4
    {2'b10, 12'h104, 2'b10, 12'h104, 32'h2,        32'h0},        // R6 same lock
    {2'b10, 12'h108, 2'b10, 12'h10C, 32'h4,        32'h8},        // R6 different locks
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h8000000E, 32'h0},        // R6
    {2'b11, 12'h104, 2'b10, 12'h104, 32'h0,        32'h0},        // R7 release vs claim held
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h8000000C, 32'h0},        // R7
    {2'b11, 12'h110, 2'b10, 12'h110, 32'h0,        32'h10},       // R7 write vs claim free
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h8000001C, 32'h0},        // R7
    {2'b10, 12'h200, 2'b11, 12'h000, 32'h0,        32'h0},        // R8 unmapped
    {2'b10, 12'h102, 2'b10, 12'h0FC, 32'h0,        32'h8000001C}, // R8 misaligned
    {2'b10, 12'h0FC, 2'b00, 12'h000, 32'h8000001C, 32'h0},        // R8 no claim by misaligned
    {2'b00, 12'h000, 2'b00, 12'h000, 32'h0,        32'h0}         // R9 idle
  };
  string tag [0:NV-1];

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input logic r0, w0, input logic [AW-1:0] a0,
                       input logic r1, w1, input logic [AW-1:0] a1);
    req[0] = r0; we[0] = w0; addr[0] = a0;
    req[1] = r1; we[1] = w1; addr[1] = a1;
    @(negedge clk);
    req = '0; we = '0; addr = '0;
  endtask

  initial begin
    tag = '{"R1","R2","R3","R3","R5","R5","R5","R4","R4","R6",
            "R6","R6","R7","R7","R7","R7","R8","R8","R8","R9"};
    repeat (3) @(negedge clk);
    check(rdata[0], '0, "R1 rdata0 in reset");
    check(rdata[1], '0, "R1 rdata1 in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[91], v[90], v[89:78], v[77], v[76], v[75:64]);
      check(rdata[0], v[63:32], $sformatf("%s vector %0d port0", tag[i], i));
      check(rdata[1], v[31:0],  $sformatf("%s vector %0d port1", tag[i], i));
    end

    // R1: block reset frees held locks
    rst_n = 1'b0;
    @(negedge clk);
    check(rdata[0], '0, "R1 rdata0 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 1'b0, 12'h0FC, 1'b0, 1'b0, 12'h000);
    check(rdata[0], '0, "R1 status after mid-run reset");
    drive(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 12'h110);
    check(rdata[1], 32'h10, "R2 reclaim lock 4 after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule